// File: doc/BRIEF.md
# Regulator Powerup Sequencer

This block orders the startup of a voltage regulator controller. It stays idle until the supply is above its undervoltage threshold and the enable pin is high. It then runs a fixed chain: an internal reset window, a wait for phase-count detection, and a soft-start ramp that ends at the boot voltage. A dwell at the boot voltage follows. Next the active-low clock-enable output is asserted, the external target code is latched, and a delayed power-good release completes the chain.

Every duration is a parameterized cycle count. One shared down-counter times all of them and is loaded by the control state machine. The analog ramp and the capacitors lie outside the block. The block only reports when the ramp may start, through `ssGo`, and learns when it has finished, through `ssDone`.

If the supply drops or enable goes low, the chain is abandoned from any state. The block returns to idle with every output inactive, which also discharges the soft-start and the power-good delay. A fresh cycle then starts from the beginning.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset the outputs are inactive: `resetActive`=0, `ssGo`=0, `bootSel`=0, `clkEnN`=1, `codeLatch`=0 and `pwrGood`=0.
- R2: The sequence starts only in a cycle where both `supplyOk` and `enPin` are sampled high. Otherwise the block stays idle with all outputs inactive.
- R3: `resetActive` is high for exactly RST_CYC cycles. The window begins in the cycle after the start condition is sampled.
- R4: After the reset window, `ssGo` stays low until `phaseDone` is sampled high. It rises in the following cycle.
- R5: `bootSel` is high while soft-start and the boot dwell run. Once `ssDone` is sampled, `bootSel` stays high for exactly BOOT_CYC more cycles. `clkEnN` falls in the cycle in which `bootSel` falls.
- R6: `codeLatch` is a single-cycle pulse. It occurs exactly one cycle after `clkEnN` falls, so the code is never read before clock-enable is low.
- R7: `pwrGood` rises exactly PG_CYC cycles after `clkEnN` falls. It then stays high while supply and enable remain good.
- R8: In any state, if `supplyOk` or `enPin` is sampled low, the next cycle shows all outputs inactive, as in R1.
- R9: After an abort, a new start repeats the full chain with unchanged durations. When `phaseDone` and `ssDone` are held high, `pwrGood` first shows RST_CYC+BOOT_CYC+PG_CYC+2 cycles after the first cycle of the reset window.
- R10: `pwrGood` high implies `clkEnN` low, and `clkEnN` low implies `ssGo` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyOk | input | 1 | Supply above undervoltage threshold |
| enPin | input | 1 | Enable request |
| phaseDone | input | 1 | Phase-count detection finished |
| ssDone | input | 1 | Soft-start ramp reached boot voltage |
| resetActive | output | 1 | Internal reset window in progress |
| ssGo | output | 1 | Soft-start may run / regulator active |
| bootSel | output | 1 | Regulate at boot voltage |
| clkEnN | output | 1 | Clock enable, active low |
| codeLatch | output | 1 | One-cycle strobe to capture target code |
| pwrGood | output | 1 | Power-good release |

## Verification
The bench builds the block with RST_CYC=20, BOOT_CYC=30 and PG_CYC=40 instead of the real-time defaults. With these values a complete chain lasts about a hundred cycles, so many full sequences fit in one run. Random aborts therefore land in every state, including the single-cycle latch point and the settled power-good state. Directed timed runs check the total chain length before and after an abort, and the idle-hold cases check each input low on its own.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RESET  = 3'd1,
    ST_PHASE  = 3'd2,
    ST_SOFT   = 3'd3,
    ST_BOOT   = 3'd4,
    ST_PGWAIT = 3'd5,
    ST_READY  = 3'd6
  } seqState_t;

  // Strobes from control to the timer datapath
  typedef struct packed {
    logic clr;
    logic ldRst;
    logic ldBoot;
    logic ldPg;
  } tmrCmd_t;

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
  import pwrseq_pkg::*;
#(
  parameter int RST_CYC  = 2750,
  parameter int BOOT_CYC = 5000,
  parameter int PG_CYC   = 450000,
  parameter int CNT_W    = 19
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmrCmd_t cmd,
  output logic    expired,
  output logic    latchPt
);

  localparam logic [CNT_W-1:0] RST_LD  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] BOOT_LD = CNT_W'(BOOT_CYC - 1);
  localparam logic [CNT_W-1:0] PG_LD   = CNT_W'(PG_CYC - 1);
  localparam logic [CNT_W-1:0] LAT_AT  = CNT_W'(PG_CYC - 2);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (cmd.clr)    cnt <= '0;
    else if (cmd.ldRst)  cnt <= RST_LD;
    else if (cmd.ldBoot) cnt <= BOOT_LD;
    else if (cmd.ldPg)   cnt <= PG_LD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
  assign latchPt = (cnt == LAT_AT);

  // R3: reset window load gives the full count
  a_r3_rst_load: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.ldRst && !cmd.clr) |=> (cnt == RST_LD));

  // R7: timer counts down by one when left alone
  a_r7_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == '0 && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R8: a clear empties the timer
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> expired);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    supplyOk,
  input  logic    enPin,
  input  logic    phaseDone,
  input  logic    ssDone,
  input  logic    tmrExpired,
  input  logic    latchPt,
  output tmrCmd_t cmd,
  output logic    resetActive,
  output logic    ssGo,
  output logic    bootSel,
  output logic    clkEnN,
  output logic    codeLatch,
  output logic    pwrGood
);

  seqState_t state, nextState;
  logic runOk;

  assign runOk = supplyOk && enPin;

  always_comb begin
    nextState = state;
    cmd       = '0;
    if (!runOk) begin
      nextState = ST_IDLE;
      cmd.clr   = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          nextState = ST_RESET;
          cmd.ldRst = 1'b1;
        end
        ST_RESET:  if (tmrExpired) nextState = ST_PHASE;
        ST_PHASE:  if (phaseDone)  nextState = ST_SOFT;
        ST_SOFT: if (ssDone) begin
          nextState  = ST_BOOT;
          cmd.ldBoot = 1'b1;
        end
        ST_BOOT: if (tmrExpired) begin
          nextState = ST_PGWAIT;
          cmd.ldPg  = 1'b1;
        end
        ST_PGWAIT: if (tmrExpired) nextState = ST_READY;
        ST_READY:  nextState = ST_READY;
        default:   nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign resetActive = (state == ST_RESET);
  assign ssGo        = (state == ST_SOFT) || (state == ST_BOOT) ||
                       (state == ST_PGWAIT) || (state == ST_READY);
  assign bootSel     = (state == ST_SOFT) || (state == ST_BOOT);
  assign clkEnN      = !((state == ST_PGWAIT) || (state == ST_READY));
  assign codeLatch   = (state == ST_PGWAIT) && latchPt;
  assign pwrGood     = (state == ST_READY);

  // R2: no start without both supply and enable
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !runOk) |=> (!resetActive && !ssGo && clkEnN));

  // R4: soft-start only after phase detection was seen
  a_r4_ss_after_phase: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssGo) |-> $past(phaseDone));

  // R5: clock enable falls only as the boot dwell ends
  a_r5_clk_after_boot: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEnN) |-> ($past(bootSel) && !bootSel));

  // R6: code latch only once clock enable is already low
  a_r6_latch_after_clk: assert property (@(posedge clk) disable iff (!rstN)
    codeLatch |-> ($past(!clkEnN) && !clkEnN));

  // R6: single-cycle pulse
  a_r6_latch_pulse: assert property (@(posedge clk) disable iff (!rstN)
    codeLatch |=> !codeLatch);

  // R8: abort from any state clears every output
  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    !runOk |=> (!resetActive && !ssGo && !bootSel && clkEnN && !codeLatch && !pwrGood));

  // R10: output ordering
  a_r10_pg_needs_clk: assert property (@(posedge clk) disable iff (!rstN)
    pwrGood |-> !clkEnN);
  a_r10_clk_needs_ss: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnN |-> ssGo);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwrseq_pkg::*;
#(
  parameter int RST_CYC  = 2750,
  parameter int BOOT_CYC = 5000,
  parameter int PG_CYC   = 450000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic enPin,
  input  logic phaseDone,
  input  logic ssDone,
  output logic resetActive,
  output logic ssGo,
  output logic bootSel,
  output logic clkEnN,
  output logic codeLatch,
  output logic pwrGood
);

  localparam int MAX_A = (RST_CYC > BOOT_CYC) ? RST_CYC : BOOT_CYC;
  localparam int MAX_C = (MAX_A > PG_CYC) ? MAX_A : PG_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  tmrCmd_t cmd;
  logic    tmrExpired;
  logic    latchPt;

  pwrseq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .enPin      (enPin),
    .phaseDone  (phaseDone),
    .ssDone     (ssDone),
    .tmrExpired (tmrExpired),
    .latchPt    (latchPt),
    .cmd        (cmd),
    .resetActive(resetActive),
    .ssGo       (ssGo),
    .bootSel    (bootSel),
    .clkEnN     (clkEnN),
    .codeLatch  (codeLatch),
    .pwrGood    (pwrGood)
  );

  pwrseq_timer #(
    .RST_CYC (RST_CYC),
    .BOOT_CYC(BOOT_CYC),
    .PG_CYC  (PG_CYC),
    .CNT_W   (CNT_W)
  ) i_timer (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .expired(tmrExpired),
    .latchPt(latchPt)
  );

endmodule

// File: tb/test_pwr_seq_top.sv
module test_pwr_seq_top;

  localparam int RST  = 20;
  localparam int BOOT = 30;
  localparam int PG   = 40;

  logic clk = 1'b0;
  logic rstN, supplyOk, enPin, phaseDone, ssDone;
  logic resetActive, ssGo, bootSel, clkEnN, codeLatch, pwrGood;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state: 0 idle,1 reset,2 phase,3 soft,4 boot,5 pgwait,6 ready
  int mSt = 0;
  int mCnt = 0;
  bit lastAbort = 0;

  always #10 clk = ~clk;

  pwr_seq_top #(.RST_CYC(RST), .BOOT_CYC(BOOT), .PG_CYC(PG)) i_pwr_seq_top (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enPin(enPin),
    .phaseDone(phaseDone), .ssDone(ssDone), .resetActive(resetActive),
    .ssGo(ssGo), .bootSel(bootSel), .clkEnN(clkEnN), .codeLatch(codeLatch),
    .pwrGood(pwrGood)
  );

  // {resetActive, ssGo, bootSel, clkEnN, codeLatch, pwrGood}
  function automatic logic [5:0] expVec(int st, int cnt);
    logic [5:0] v;
    v[5] = (st == 1);
    v[4] = (st >= 3);
    v[3] = (st == 3) || (st == 4);
    v[2] = !(st >= 5);
    v[1] = (st == 5) && (cnt == PG - 2);
    v[0] = (st == 6);
    return v;
  endfunction

  function automatic string tagOf(logic [5:0] diff, bit ab);
    if (ab)      return "R8";
    if (diff[5]) return "R3 resetActive";
    if (diff[4]) return "R4 ssGo";
    if (diff[3]) return "R5 bootSel";
    if (diff[2]) return "R5 clkEnN";
    if (diff[1]) return "R6 codeLatch";
    return "R7 pwrGood";
  endfunction

  function automatic logic [5:0] actVec();
    return {resetActive, ssGo, bootSel, clkEnN, codeLatch, pwrGood};
  endfunction

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic modelStep(bit s, bit e, bit p, bit d);
    lastAbort = !(s && e);
    if (!(s && e)) begin
      mSt = 0; mCnt = 0;
    end else begin
      case (mSt)
        0: begin mSt = 1; mCnt = RST - 1; end
        1: if (mCnt == 0) mSt = 2; else mCnt--;
        2: if (p) mSt = 3;
        3: if (d) begin mSt = 4; mCnt = BOOT - 1; end
        4: if (mCnt == 0) begin mSt = 5; mCnt = PG - 1; end else mCnt--;
        5: if (mCnt == 0) mSt = 6; else mCnt--;
        default: mSt = 6;
      endcase
    end
  endtask

  task automatic cycleStep(bit s, bit e, bit p, bit d);
    logic [5:0] a, x;
    @(negedge clk);
    a = actVec();
    x = expVec(mSt, mCnt);
    chk(tagOf(a ^ x, lastAbort), a, x);
    total++;
    if ((pwrGood && clkEnN) || (!clkEnN && !ssGo)) begin
      bad++;
      $display("FAIL R10 actual=%b expected=ordered outputs", a);
    end
    supplyOk = s; enPin = e; phaseDone = p; ssDone = d;
    modelStep(s, e, p, d);
  endtask

  // R9 / timing: from idle with phaseDone and ssDone held high
  task automatic timedRun(string tag);
    int n = 0;
    bit seen = 0;
    while (!seen && n < 1000) begin
      cycleStep(1, 1, 1, 1);
      n++;
      if (pwrGood) seen = 1;
    end
    total++;
    if (n != RST + BOOT + PG + 4) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, n, RST + BOOT + PG + 4);
    end
  endtask

  initial begin
    void'($urandom(32'd7341));
    rstN = 0; supplyOk = 0; enPin = 0; phaseDone = 0; ssDone = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", actVec(), 6'b000100);
    rstN = 1;
    // R2: enable low with supply good, then supply low with enable high
    repeat (40) cycleStep(1, 0, 1, 1);
    chk("R2 enable low keeps idle", actVec(), 6'b000100);
    repeat (40) cycleStep(0, 1, 1, 1);
    chk("R2 supply low keeps idle", actVec(), 6'b000100);
    // R3..R7 full timed chain, then abort and R9 repeat
    timedRun("R7 chain length");
    repeat (5) cycleStep(1, 1, 0, 0);
    cycleStep(1, 0, 0, 0);
    cycleStep(1, 1, 0, 0);
    chk("R8 abort from ready", actVec(), 6'b000100);
    cycleStep(0, 0, 0, 0);
    timedRun("R9 chain after abort");
    // R4: phaseDone withheld, ssGo must stay low
    cycleStep(0, 0, 0, 0);
    repeat (RST + 15) cycleStep(1, 1, 0, 1);
    chk("R4 waits for phaseDone", actVec(), 6'b000100);
    // random mix
    for (int i = 0; i < 15000; i++) begin
      bit s, e, p, d;
      s = ($urandom % 400) != 0;
      e = ($urandom % 400) != 0;
      p = ($urandom % 6) == 0;
      d = ($urandom % 8) == 0;
      cycleStep(s, e, p, d);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule